// File: doc/BRIEF.md
# Aperiodic Port Event Status Collector

This block gathers one-cycle event pulses from a set of line ports and keeps them as sticky bits in one read-only status word. Each port has four events: a new command/indication (C/I) value has arrived, the C/I transmit register has gone empty, a monitor byte has been sent, and a monitor byte has been received. The status word has no write path from the CPU. Instead, each bit clears as a side effect of the CPU access that deals with the event: a read of the matching receive register, a read of the shared C/I transmit status register, or a write of the monitor transmit register. The block takes those accesses as strobes.

A mask word with the same layout as the status word picks which bits may raise the interrupt. The single interrupt output is a registered level. It stays high for as long as any unmasked status bit is set. A synchronous hardware reset and a software clear input both return the whole word to zero.

Top module: `aprs_status_top`

## Requirements
- R1: While `rst` is high at a clock edge, `stat_word` becomes 0x0000 and `irq` becomes 0 after that edge.
- R2: A `sw_clr` pulse clears every status bit and `irq` at the next edge. It wins over any event in the same cycle.
- R3: Port p owns bits 15-4p down to 12-4p. Inside that nibble, from the top bit down, the order is: C/I received (bit 3), C/I transmit empty (bit 2), monitor transmitted (bit 1), monitor received (bit 0).
- R4: An event pulse sets its bit at the next clock edge. The bit stays set until its own clear arrives.
- R5: `ci_rx_rd[p]` clears only the C/I-received bit of port p.
- R6: One `ci_tx_stat_rd` pulse clears the C/I-transmit-empty bit of all ports.
- R7: `mon_rx_rd[p]` clears only the monitor-received bit of port p.
- R8: `mon_tx_wr[p]` clears only the monitor-transmitted bit of port p.
- R9: When a set and a clear reach the same bit in one cycle, the bit ends up set.
- R10: `irq` is high one edge after `stat_word & irq_en` is nonzero, and low one edge after it is zero. A change of `irq_en` alone therefore shows on `irq` one cycle later.
- R11: A set status bit whose `irq_en` bit is 0 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_clr | input | 1 | Software reset pulse, clears the status word |
| ci_rx_evt | input | NUM_PORTS | New C/I value received, one bit per port |
| ci_tx_evt | input | NUM_PORTS | C/I transmit register went empty, per port |
| mon_tx_evt | input | NUM_PORTS | Monitor byte transmitted, per port |
| mon_rx_evt | input | NUM_PORTS | Monitor byte received, per port |
| ci_rx_rd | input | NUM_PORTS | CPU read of the port's C/I receive register |
| ci_tx_stat_rd | input | 1 | CPU read of the shared C/I transmit status register |
| mon_rx_rd | input | NUM_PORTS | CPU read of the port's monitor receive register |
| mon_tx_wr | input | NUM_PORTS | CPU write of the port's monitor transmit register |
| irq_en | input | 4*NUM_PORTS | Interrupt mask, same layout as the status word |
| stat_word | output | 4*NUM_PORTS | Registered status word for CPU reads |
| irq | output | 1 | Registered aggregated interrupt level |

## Verification
The assertions assume that every event and strobe input is synchronous to `clk`, with a known value at each edge once reset is released. They also assume that a strobe lasting several cycles counts as repeated accesses, not as one. The stimulus changes inputs only on the falling edge. Each strobe or event stays high for exactly one cycle, and the interrupt is sampled one cycle after the status word, so that no pulse merges with the next one. Same-cycle set/clear pairs and clears aimed at the wrong port are driven on purpose, to test priority and isolation.

// File: rtl/aprs_pkg.sv
package aprs_pkg;
  localparam int unsigned EVT_PER_PORT = 4;
  // bit positions inside one port nibble
  localparam int unsigned NB_MON_RX = 0;
  localparam int unsigned NB_MON_TX = 1;
  localparam int unsigned NB_CI_TX  = 2;
  localparam int unsigned NB_CI_RX  = 3;

  typedef logic [EVT_PER_PORT-1:0] nib_t;

  // lowest status-word bit of port p
  function automatic int unsigned port_base(input int unsigned p,
                                            input int unsigned nports);
    return (nports - 1 - p) * EVT_PER_PORT;
  endfunction
endpackage

// File: rtl/aprs_route.sv
module aprs_route
  import aprs_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] ci_rx_i,
  input  logic [NUM_PORTS-1:0] ci_tx_i,
  input  logic [NUM_PORTS-1:0] mon_tx_i,
  input  logic [NUM_PORTS-1:0] mon_rx_i,
  output nib_t                 nib_o [NUM_PORTS]
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      nib_o[p]            = '0;
      nib_o[p][NB_CI_RX]  = ci_rx_i[p];
      nib_o[p][NB_CI_TX]  = ci_tx_i[p];
      nib_o[p][NB_MON_TX] = mon_tx_i[p];
      nib_o[p][NB_MON_RX] = mon_rx_i[p];
    end
  end
endmodule

// File: rtl/aprs_nibble.sv
module aprs_nibble
  import aprs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_clr,
  input  nib_t set_i,
  input  nib_t clr_i,
  output nib_t q_o
);
  nib_t q;

  // set is OR-ed in after the clear mask, so it wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (rst || sw_clr) q <= '0;
    else               q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;

  for (genvar b = 0; b < EVT_PER_PORT; b++) begin : g_chk
    // R4 R9
    bit_set_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i[b] && !sw_clr) |=> q[b]);
    // R5 R7 R8
    bit_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !q[b]);
    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_i[b] && !clr_i[b] && !sw_clr) |=> $stable(q[b]));
  end

  // R2
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_clr |=> (q == '0));
endmodule

// File: rtl/aprs_irq_reg.sv
module aprs_irq_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_clr,
  input  logic [WIDTH-1:0] stat_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst || sw_clr) irq_q <= 1'b0;
    else               irq_q <= |(stat_i & en_i);
  end

  assign irq_o = irq_q;

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(stat_i & en_i)) && !sw_clr) |=> irq_q);
  // R10 R11
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|(stat_i & en_i))) |=> !irq_q);
endmodule

// File: rtl/aprs_status_top.sv
module aprs_status_top
  import aprs_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned WIDTH = NUM_PORTS * EVT_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_clr,
  input  logic [NUM_PORTS-1:0] ci_rx_evt,
  input  logic [NUM_PORTS-1:0] ci_tx_evt,
  input  logic [NUM_PORTS-1:0] mon_tx_evt,
  input  logic [NUM_PORTS-1:0] mon_rx_evt,
  input  logic [NUM_PORTS-1:0] ci_rx_rd,
  input  logic                 ci_tx_stat_rd,
  input  logic [NUM_PORTS-1:0] mon_rx_rd,
  input  logic [NUM_PORTS-1:0] mon_tx_wr,
  input  logic [WIDTH-1:0]     irq_en,
  output logic [WIDTH-1:0]     stat_word,
  output logic                 irq
);
  nib_t set_nib [NUM_PORTS];
  nib_t clr_nib [NUM_PORTS];
  nib_t q_nib   [NUM_PORTS];
  logic [WIDTH-1:0] stat_w;

  aprs_route #(.NUM_PORTS(NUM_PORTS)) u_set_route (
    .ci_rx_i (ci_rx_evt),
    .ci_tx_i (ci_tx_evt),
    .mon_tx_i(mon_tx_evt),
    .mon_rx_i(mon_rx_evt),
    .nib_o   (set_nib)
  );

  // the transmit status read is shared by every port
  aprs_route #(.NUM_PORTS(NUM_PORTS)) u_clr_route (
    .ci_rx_i (ci_rx_rd),
    .ci_tx_i ({NUM_PORTS{ci_tx_stat_rd}}),
    .mon_tx_i(mon_tx_wr),
    .mon_rx_i(mon_rx_rd),
    .nib_o   (clr_nib)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned BASE = port_base(p, NUM_PORTS);

    aprs_nibble u_nib (
      .clk   (clk),
      .rst   (rst),
      .sw_clr(sw_clr),
      .set_i (set_nib[p]),
      .clr_i (clr_nib[p]),
      .q_o   (q_nib[p])
    );

    assign stat_w[BASE +: EVT_PER_PORT] = q_nib[p];

    // R3
    layout_cirx_chk: assert property (@(posedge clk) disable iff (rst)
      (ci_rx_evt[p] && !sw_clr) |=> stat_w[BASE + NB_CI_RX]);
    // R3
    layout_monrx_chk: assert property (@(posedge clk) disable iff (rst)
      (mon_rx_evt[p] && !sw_clr) |=> stat_w[BASE + NB_MON_RX]);
    // R6
    citx_shared_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (ci_tx_stat_rd && !ci_tx_evt[p]) |=> !stat_w[BASE + NB_CI_TX]);
  end

  aprs_irq_reg #(.WIDTH(WIDTH)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .sw_clr(sw_clr),
    .stat_i(stat_w),
    .en_i  (irq_en),
    .irq_o (irq)
  );

  assign stat_word = stat_w;

  // R1
  hw_reset_chk: assert property (@(posedge clk)
    rst |=> ((stat_w == '0) && !irq));
endmodule

// File: tb/sim_aprs_status_top.sv
module sim_aprs_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int W  = 16;
  localparam int NV = 13;

  // {set[15:0], clr[12:0], en[15:0], exp_stat[15:0], exp_irq}
  // clr: [12:9] ci_rx_rd by port, [8] ci_tx_stat_rd, [7:4] mon_rx_rd, [3:0] mon_tx_wr
  localparam logic [61:0] VEC [NV] = '{
    {16'h8000, 13'h0000, 16'hFFFF, 16'h8000, 1'b1}, // R3 R4 p0 C/I rx
    {16'h0400, 13'h0000, 16'h0000, 16'h8400, 1'b0}, // R11 masked
    {16'h0021, 13'h0000, 16'h0001, 16'h8421, 1'b1}, // R3 p2 mon tx, p3 mon rx
    {16'h0000, 13'h0200, 16'hFFFF, 16'h0421, 1'b1}, // R5 p0 rx read
    {16'h0044, 13'h0000, 16'h8000, 16'h0465, 1'b0}, // R4 R11
    {16'h0000, 13'h0100, 16'h0020, 16'h0021, 1'b1}, // R6 shared tx read
    {16'h0000, 13'h0004, 16'h0020, 16'h0001, 1'b0}, // R8 p2 mon write
    {16'h0000, 13'h0080, 16'hFFFF, 16'h0000, 1'b0}, // R7 p3 mon read
    {16'h0008, 13'h1000, 16'h0008, 16'h0008, 1'b1}, // R9 set beats clear
    {16'h0000, 13'h0200, 16'h0000, 16'h0008, 1'b0}, // R5 wrong port read
    {16'hFFFF, 13'h0000, 16'h1000, 16'hFFFF, 1'b1}, // R4 all set
    {16'h0000, 13'h1FFF, 16'hFFFF, 16'h0000, 1'b0}, // R5 R6 R7 R8 all clear
    {16'h1248, 13'h0000, 16'h0100, 16'h1248, 1'b0}  // R3 R11
  };

  logic clk = 1'b0;
  logic rst, sw_clr, ci_tx_stat_rd, irq;
  logic [NP-1:0] ci_rx_evt, ci_tx_evt, mon_tx_evt, mon_rx_evt;
  logic [NP-1:0] ci_rx_rd, mon_rx_rd, mon_tx_wr;
  logic [W-1:0]  irq_en, stat_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aprs_status_top #(.NUM_PORTS(NP)) u0 (
    .clk(clk), .rst(rst), .sw_clr(sw_clr),
    .ci_rx_evt(ci_rx_evt), .ci_tx_evt(ci_tx_evt),
    .mon_tx_evt(mon_tx_evt), .mon_rx_evt(mon_rx_evt),
    .ci_rx_rd(ci_rx_rd), .ci_tx_stat_rd(ci_tx_stat_rd),
    .mon_rx_rd(mon_rx_rd), .mon_tx_wr(mon_tx_wr),
    .irq_en(irq_en), .stat_word(stat_word), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_clr = 0; ci_tx_stat_rd = 0;
    ci_rx_evt = '0; ci_tx_evt = '0; mon_tx_evt = '0; mon_rx_evt = '0;
    ci_rx_rd = '0; mon_rx_rd = '0; mon_tx_wr = '0;
  endtask

  // map a status-layout mask onto event inputs (R3 layout)
  task automatic drive_set(input logic [15:0] m);
    for (int p = 0; p < NP; p++) begin
      ci_rx_evt[p]  = m[15 - 4*p];
      ci_tx_evt[p]  = m[14 - 4*p];
      mon_tx_evt[p] = m[13 - 4*p];
      mon_rx_evt[p] = m[12 - 4*p];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    irq_en = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset stat", 32'(stat_word), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      @(negedge clk);
      drive_set(v[61:46]);
      ci_rx_rd      = v[45:42];
      ci_tx_stat_rd = v[41];
      mon_rx_rd     = v[40:37];
      mon_tx_wr     = v[36:33];
      irq_en        = v[32:17];
      @(posedge clk); #1;
      idle_inputs();
      check($sformatf("R3/R4..R9 vec %0d stat", i), 32'(stat_word), 32'(v[16:1]));
      @(posedge clk); #1;
      check($sformatf("R10/R11 vec %0d irq", i), 32'(irq), 32'(v[0]));
    end

    // R10: a mask change alone reaches irq one cycle later (stat = 0x1248)
    @(negedge clk); irq_en = 16'h0008;
    check("R10 irq before edge", 32'(irq), 32'h0);
    @(posedge clk); #1;
    check("R10 irq after mask change", 32'(irq), 32'h1);

    // R2: software clear wins over a same-cycle event
    @(negedge clk); sw_clr = 1'b1; drive_set(16'h0100);
    @(posedge clk); #1; idle_inputs();
    check("R2 sw clear stat", 32'(stat_word), 32'h0);
    check("R2 sw clear irq", 32'(irq), 32'h0);

    // R1: hardware reset mid-run
    @(negedge clk); drive_set(16'h0800); irq_en = 16'hFFFF;
    @(posedge clk); #1; idle_inputs();
    check("R4 p1 C/I rx", 32'(stat_word), 32'h0800);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset stat", 32'(stat_word), 32'h0);
    check("R1 mid reset irq", 32'(irq), 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    finish_run();
  end
endmodule